// File: doc/BRIEF.md
# Latency-Insensitive Module Shell

This block wraps a small synchronous function so that it tolerates any delay on its channels. Each input channel delivers packets made of a payload and a void flag. A void flag of 1 marks an empty slot, and a void flag of 0 marks a true value. The shell keeps a one-entry holding buffer per input. It fires the wrapped function only when every buffer holds a true value. It then offers the result downstream as a true packet. Every channel carries a stop line running against the data flow, so a receiver can refuse a packet.

The wrapped function is a registered sum of all operands, taken modulo 2^W. It advances only in cycles where the shell fires it, so it stalls cleanly. A two-state machine drives the output channel:
- **COLLECT**: no result is pending and the output is void.
- **SEND**: a result is on the output as a true packet.

The machine has four transitions:
- **launch**: COLLECT to SEND, when all buffers are full.
- **refire**: SEND to SEND, when the result leaves and all buffers are full again.
- **drain**: SEND to COLLECT, when the result leaves and some buffer is empty.
- **hold**: SEND to SEND, when the result is stopped downstream.

Top module: `li_shell`

## Requirements
- R1: After reset every holding buffer is empty, the output state is COLLECT with `out_void`=1, and every bit of `in_stop` is 0.
- R2: An input packet with void=1 is never stored and never becomes an operand.
- R3: The function fires only when every input buffer holds a true packet, and each firing pairs the i-th true packet of every channel.
- R4: The result of a firing appears one clock later on `out_data` with `out_void`=0, and equals the sum of the operands modulo 2^W.
- R5: While `out_void`=0 and `out_stop`=1, no firing takes place and `out_data` and `out_void` stay unchanged in the next cycle.
- R6: When no result is pending, `out_void` is 1.
- R7: `in_stop[i]` is 1 only while buffer i is full and cannot drain in this cycle. An empty channel is never stopped.
- R8: A firing empties all buffers in the same edge, and a packet offered in that cycle is accepted. With no voids and no stops, the shell accepts one packet per channel and emits one result per cycle.
- R9: For any pattern of input voids and output stops, the sequence of true outputs equals the sequence of sums of the unwrapped function over the true inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | N_IN*W | Payloads, channel i in bits [i*W +: W] |
| in_void | input | N_IN | Void flag per input channel (1 = empty slot) |
| in_stop | output | N_IN | Backpressure to each input source |
| out_data | output | W | Result payload |
| out_void | output | 1 | Void flag of the output packet |
| out_stop | input | 1 | Backpressure from the downstream sink |

## Verification
The bench sweeps all 256 operand pairs of a 4-bit, two-channel shell. It randomises input voids, output stops and the garbage carried by void packets. A shell that let void packets through would shift the pairing and corrupt the sums. One that fired with a channel missing would do the same. One that advanced the output under stop would drop or repeat results, and the stable-output check catches that. A directed burst with no voids and no stops targets the same-cycle refill. A design that stopped a full buffer even while it was firing would show a spurious stop and lose throughput.

// File: rtl/li_pkg.sv
package li_pkg;
    typedef enum logic [0:0] {
        ST_COLLECT = 1'b0,
        ST_SEND    = 1'b1
    } out_state_t;
endpackage

// File: rtl/li_in_slot.sv
module li_in_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pkt_data,
    input  logic         pkt_void,
    input  logic         consume,
    output logic         stop_up,
    output logic         full,
    output logic [W-1:0] held
);
    logic take;

    always_comb begin
        stop_up = full && !consume;
        take    = !pkt_void && !stop_up;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            held <= '0;
        end else begin
            if (consume) begin
                full <= take;
            end else if (take) begin
                full <= 1'b1;
            end
            if (take) begin
                held <= pkt_data;
            end
        end
    end

    AST_EMPTY_NEVER_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !full |-> !stop_up); // R7

    AST_CLEAR_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && pkt_void) |=> !full); // R8

    AST_VOID_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!full && pkt_void) |=> !full); // R2
endmodule

// File: rtl/li_core.sv
module li_core #(
    parameter int N_IN = 2,
    parameter int W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [N_IN*W-1:0] operands,
    output logic [W-1:0]      result
);
    logic [W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = 0; i < N_IN; i++) begin
            acc = acc + operands[i*W +: W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (en) begin
            result <= acc;
        end
    end
endmodule

// File: rtl/li_shell.sv
module li_shell
    import li_pkg::*;
#(
    parameter int N_IN = 2,
    parameter int W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN*W-1:0] in_data,
    input  logic [N_IN-1:0]   in_void,
    output logic [N_IN-1:0]   in_stop,
    output logic [W-1:0]      out_data,
    output logic              out_void,
    input  logic              out_stop
);
    localparam int OPW = N_IN * W;

    out_state_t        state, state_nx;
    logic [N_IN-1:0]   full;
    logic [OPW-1:0]    operands;
    logic              all_full;
    logic              out_free;
    logic              fire;

    for (genvar g = 0; g < N_IN; g++) begin : g_slot
        li_in_slot #(.W(W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .pkt_data (in_data[g*W +: W]),
            .pkt_void (in_void[g]),
            .consume  (fire),
            .stop_up  (in_stop[g]),
            .full     (full[g]),
            .held     (operands[g*W +: W])
        );
    end

    always_comb begin
        all_full = &full;
        out_free = (state == ST_COLLECT) || !out_stop;
        fire     = all_full && out_free;
    end

    li_core #(.N_IN(N_IN), .W(W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (fire),
        .operands (operands),
        .result   (out_data)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COLLECT: if (fire) state_nx = ST_SEND;
            ST_SEND:    if (!out_stop) state_nx = fire ? ST_SEND : ST_COLLECT;
            default:    state_nx = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_COLLECT;
        else        state <= state_nx;
    end

    always_comb begin
        out_void = (state != ST_SEND);
    end

    AST_HOLD_WHILE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_void && out_stop) |=> (!out_void && $stable(out_data))); // R5

    AST_NO_FIRE_WHILE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_void && out_stop) |-> !fire); // R5

    AST_FIRE_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !out_void); // R4

    AST_NO_FIRE_WITH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        !all_full |=> $stable(out_data)); // R3
endmodule

// File: tb/li_shell_test.sv
`timescale 1ns/1ps
module li_shell_test;
    localparam int N = 2;
    localparam int W = 4;
    localparam int TOTAL = 256;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N*W-1:0] in_data = '0;
    logic [N-1:0]   in_void = '1;
    logic [N-1:0]   in_stop;
    logic [W-1:0]   out_data;
    logic           out_void;
    logic           out_stop = 1'b0;

    int checks = 0;
    int errors = 0;
    int k[N];
    bit pres[N];
    int nout = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit prev_hold = 0;
    logic [W-1:0] prev_data = '0;

    always #4 clk = ~clk;

    li_shell #(.N_IN(N), .W(W)) uut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_void(in_void),
        .in_stop(in_stop), .out_data(out_data), .out_void(out_void),
        .out_stop(out_stop)
    );

    function automatic logic [W-1:0] val_of(int ch, int idx);
        logic [7:0] b = idx[7:0];
        return (ch == 0) ? b[3:0] : b[7:4];
    endfunction

    function automatic logic [W-1:0] exp_sum(int idx);
        return val_of(0, idx) + val_of(1, idx);
    endfunction

    function automatic logic rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // mode 0: random voids/stops up to limit; mode 1: always valid, never stopped
    task automatic step(int mode, int limit);
        @(negedge clk);
        cyc++;
        for (int c = 0; c < N; c++) begin
            if (!pres[c] && k[c] < limit)
                pres[c] = (mode == 1) ? 1'b1 : (rnd() | rnd());
            in_void[c] = !pres[c];
            in_data[c*W +: W] = pres[c] ? val_of(c, k[c]) : {rnd(), rnd(), rnd(), rnd()};
        end
        out_stop = (mode == 1) ? 1'b0 : (rnd() & rnd());
        #1;
        if (prev_hold) begin
            check(out_void == 1'b0, "R5 void held", out_void, 0);
            check(out_data == prev_data, "R5 data held", out_data, prev_data);
        end
        for (int c = 0; c < N; c++) begin
            if (in_stop[c]) check(k[c] > nout, "R7 stop only with held packet", k[c], nout + 1);
            if (mode == 1) check(in_stop[c] == 1'b0, "R8 no stop in burst", in_stop[c], 0);
        end
        prev_hold = !out_void && out_stop;
        prev_data = out_data;
        if (!out_void && !out_stop) begin
            check(out_data == exp_sum(nout), "R2/R3/R4/R9 output value", out_data, exp_sum(nout));
            nout++;
        end
        for (int c = 0; c < N; c++) begin
            if (pres[c] && !in_stop[c]) begin
                k[c]++;
                pres[c] = 0;
            end
        end
    endtask

    initial begin
        for (int c = 0; c < N; c++) begin k[c] = 0; pres[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_void == 1'b1, "R1 out_void after reset", out_void, 1);
        check(in_stop == '0, "R1 in_stop after reset", in_stop, 0);

        while (nout < TOTAL && cyc < 100000) step(0, TOTAL);
        check(nout == TOTAL, "R9 result count", nout, TOTAL);

        for (int j = 0; j < 16 && cyc < 100000; j++) step(1, TOTAL + 16);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            cyc++;
            in_void = '1;
            out_stop = 1'b0;
            #1;
            if (!out_void) begin
                check(out_data == exp_sum(nout), "R8 burst output", out_data, exp_sum(nout));
                nout++;
            end
        end
        check(nout == TOTAL + 16, "R8 burst throughput count", nout, TOTAL + 16);
        check(out_void == 1'b1, "R6 void when idle", out_void, 1);
        check(in_stop == '0, "R7 idle no stop", in_stop, 0);

        @(negedge clk);
        in_void = '1;
        in_data = '1;
        out_stop = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        check(out_void == 1'b1, "R2 void inputs never fire", out_void, 1);
        check(in_stop == '0, "R2 void inputs never stored", in_stop, 0);

        if (cyc >= 100000) check(1'b0, "watchdog", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1500000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule